// File: doc/BRIEF.md
# Field-Configurable Two-Plane Logic Array

This block is a small programmable logic array with two fully programmable planes. The first plane forms product terms from the primary inputs. Each term is the AND of any chosen set of input literals, and each literal is either the true or the inverted form of an input. The second plane forms each output as the OR of any chosen set of those terms. Because both planes are programmable, one product term can feed several outputs. Any two-level sum-of-products function that fits within the term budget can be built.

The connection map is loaded one bit per clock over a two-wire shift port in a fixed order. The map that is in use does not change until the last bit of a complete load arrives. A one-cycle done pulse then marks the switch to the new map. The outputs are purely combinational from the inputs and the map in use. Reset clears the map.

Top module: `pla_array`

## Requirements
- R1: The array has 3 inputs, 5 product terms and 4 outputs. Input A is in_i[0], B is in_i[1] and C is in_i[2]. Output Fn is f_o[n]. The outputs are combinational, so f_o follows in_i in the same cycle.
- R2: A product term is the AND of the literals connected to it. A connected true literal needs its input at 1, and a connected complement literal needs its input at 0.
- R3: A product term with no literal connected evaluates to 1. A term with both literals of one input connected evaluates to 0.
- R4: An output is the OR of the terms connected to it, and one term may drive several outputs. An output with no term connected is 0.
- R5: A load is 50 bits, with bit k shifted k-th (k = 0 first) while cfg_en_i is 1. For k < 30, bit k connects a literal to term k/6: the literal belongs to input (k%6)/2 and is the complement when k is odd. For k >= 30, bit k connects term (k-30)%5 to output (k-30)/5.
- R6: While a load is in progress, the map in use is unchanged. The new map takes effect in the cycle after the clock edge that samples bit 49. cfg_done_o is 1 for exactly that one cycle.
- R7: Dropping cfg_en_i before bit 49 abandons the partial load. The map in use stays as it was, and the next load starts again at bit 0.
- R8: Asynchronous reset (rst_ni low) clears the whole map. This drives f_o to 0 and cfg_done_o to 0.
- R9: The map can realize F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A using the five shared terms AB, B'C, AC', B'C' and A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Shift enable for the configuration bits |
| cfg_bit_i | input | 1 | Serial configuration bit |
| in_i | input | 3 | Primary inputs A, B, C |
| f_o | output | 4 | Sum-of-products outputs |
| cfg_done_o | output | 1 | One-cycle pulse when a new map takes effect |

## Verification
The assertions check on every cycle that:
- cfg_done_o is a single-cycle pulse that only follows an enabled shift.
- The map in use changes only in a done cycle.
- An empty term evaluates to 1 and an empty output evaluates to 0.

Only the bench scenarios can show the rest:
- the bit ordering of a load;
- that an abandoned load leaves the old map in place;
- that outputs computed from the old map persist in the middle of a load;
- the shared-term example functions, and the complement and contradiction cases across all input patterns.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned N_IN     = 3;
  localparam int unsigned N_TERM   = 5;
  localparam int unsigned N_OUT    = 4;
  localparam int unsigned LIT_W    = 2 * N_IN;
  localparam int unsigned AND_BITS = N_TERM * LIT_W;
  localparam int unsigned OR_BITS  = N_OUT * N_TERM;
  localparam int unsigned MAP_BITS = AND_BITS + OR_BITS;
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int unsigned TOTAL = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  output logic [TOTAL-1:0] map_o,
  output logic             done_o
);
  localparam int unsigned CW = $clog2(TOTAL);

  logic [CW-1:0]    cnt_q;
  logic [TOTAL-1:0] shadow_q, shadow_d;
  logic             last;

  assign last = cfg_en_i && (cnt_q == CW'(TOTAL - 1));

  always_comb begin
    shadow_d = shadow_q;
    shadow_d[cnt_q] = cfg_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      map_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (!cfg_en_i) begin
        cnt_q <= '0;  // partial load abandoned
      end else begin
        shadow_q <= shadow_d;
        if (last) begin
          cnt_q <= '0;
          map_o <= shadow_d;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cfg_en_i));
  p_map_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(map_o));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 5
) (
  input  logic [N_IN-1:0]          in_i,
  input  logic [N_TERM*2*N_IN-1:0] map_i,
  output logic [N_TERM-1:0]        term_o
);
  localparam int unsigned LIT_W = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] sel;
    logic             acc;
    assign sel = map_i[t*LIT_W +: LIT_W];
    always_comb begin
      acc = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (sel[2*i] && !in_i[i])   acc = 1'b0;  // true literal
        if (sel[2*i+1] && in_i[i])  acc = 1'b0;  // complement literal
      end
    end
    assign term_o[t] = acc;

    always_comb begin
      if (sel == '0) p_empty_term_r3: assert (term_o[t] == 1'b1);
    end
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 5,
  parameter int unsigned N_OUT  = 4
) (
  input  logic [N_TERM-1:0]       term_i,
  input  logic [N_OUT*N_TERM-1:0] map_i,
  output logic [N_OUT-1:0]        f_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel    = map_i[o*N_TERM +: N_TERM];
    assign f_o[o] = |(sel & term_i);

    always_comb begin
      if (sel == '0) p_empty_out_r4: assert (f_o[o] == 1'b0);
    end
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned IN_W   = N_IN,
  parameter int unsigned TERM_N = N_TERM,
  parameter int unsigned OUT_W  = N_OUT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] f_o,
  output logic             cfg_done_o
);
  localparam int unsigned A_BITS = TERM_N * 2 * IN_W;
  localparam int unsigned O_BITS = OUT_W * TERM_N;
  localparam int unsigned T_BITS = A_BITS + O_BITS;

  logic [T_BITS-1:0] map;
  logic [TERM_N-1:0] term;

  pla_cfg_loader #(.TOTAL(T_BITS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_en_i (cfg_en_i),
    .cfg_bit_i(cfg_bit_i),
    .map_o    (map),
    .done_o   (cfg_done_o)
  );

  pla_and_plane #(.N_IN(IN_W), .N_TERM(TERM_N)) u_and (
    .in_i  (in_i),
    .map_i (map[A_BITS-1:0]),
    .term_o(term)
  );

  pla_or_plane #(.N_TERM(TERM_N), .N_OUT(OUT_W)) u_or (
    .term_i(term),
    .map_i (map[T_BITS-1:A_BITS]),
    .f_o   (f_o)
  );

  p_out_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_done_o && $stable(in_i)) |-> $stable(f_o));
endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0] in;
    logic [3:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [2:0] in_r = '0;
  logic [3:0] f;
  logic       done;

  int n_tests = 0;
  int n_fail  = 0;
  item_t q[$];

  bit [29:0] and_v, and_new;
  bit [19:0] or_v, or_new;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .in_i(in_r), .f_o(f), .cfg_done_o(done)
  );

  function automatic logic [3:0] model(bit [29:0] av, bit [19:0] ov, logic [2:0] x);
    logic [4:0] tm;
    logic [3:0] r;
    for (int t = 0; t < 5; t++) begin
      tm[t] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        if (av[t*6+2*i]   && !x[i]) tm[t] = 1'b0;
        if (av[t*6+2*i+1] &&  x[i]) tm[t] = 1'b0;
      end
    end
    for (int o = 0; o < 4; o++) r[o] = |(ov[o*5 +: 5] & tm);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(f === it.exp, it.req, int'(f), int'(it.exp));
    end
  end

  task automatic apply(logic [2:0] x, string req);
    item_t it;
    @(posedge clk); #1;
    in_r = x;
    it.in = x; it.exp = model(and_v, or_v, x); it.req = req;
    q.push_back(it);
  endtask

  task automatic sweep(string req);
    for (int x = 0; x < 8; x++) apply(3'(x), req);
    @(posedge clk);
  endtask

  task automatic lit(int t, int i, bit comp);
    and_new[t*6+2*i+int'(comp)] = 1'b1;
  endtask

  task automatic con(int o, int t);
    or_new[o*5+t] = 1'b1;
  endtask

  // shift nbits of the new map; full load when nbits == 50
  task automatic load(int nbits);
    bit [49:0] v;
    v = {or_new, and_new};
    for (int k = 0; k < nbits; k++) begin
      @(posedge clk); #1;
      cfg_en = 1'b1; cfg_bit = v[k];
      if (k == 25) begin
        item_t it;
        it.in = in_r; it.exp = model(and_v, or_v, in_r); it.req = "R6 mid-load";
        q.push_back(it);
      end
    end
    @(posedge clk); #1;
    cfg_en = 1'b0;
    if (nbits == 50) begin
      and_v = and_new; or_v = or_new;
      @(negedge clk);
      chk(done === 1'b1, "R6 done pulse", int'(done), 1);
      chk(f === model(and_v, or_v, in_r), "R5 new map", int'(f), int'(model(and_v, or_v, in_r)));
      @(negedge clk);
      chk(done === 1'b0, "R6 done single", int'(done), 0);
    end else begin
      @(negedge clk);
      chk(done === 1'b0, "R7 no done on abort", int'(done), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    and_v = '0; or_v = '0;
    #(CLK_PERIOD*2 + 2);
    // R8: reset state
    chk(f === 4'h0, "R8 reset outputs", int'(f), 0);
    chk(done === 1'b0, "R8 reset done", int'(done), 0);
    rst_n = 1'b1;
    sweep("R8 empty map");

    // R9 example with shared terms: t0=AB t1=B'C t2=AC' t3=B'C' t4=A
    and_new = '0; or_new = '0;
    lit(0,0,0); lit(0,1,0);
    lit(1,1,1); lit(1,2,0);
    lit(2,0,0); lit(2,2,1);
    lit(3,1,1); lit(3,2,1);
    lit(4,0,0);
    con(0,4); con(0,3);
    con(1,2); con(1,0);
    con(2,3); con(2,0);
    con(3,1); con(3,4);
    load(50);
    sweep("R9 example");
    sweep("R4 shared terms");
    // R1: combinational same-cycle response
    @(posedge clk); #1; in_r = 3'b001;
    #1 chk(f === model(and_v, or_v, 3'b001), "R1 combinational", int'(f), int'(model(and_v, or_v, 3'b001)));

    // second map: t0 empty, t1 A.A', t2 C', t3 A.B
    and_new = '0; or_new = '0;
    lit(1,0,0); lit(1,0,1);
    lit(2,2,1);
    lit(3,0,0); lit(3,1,0);
    con(0,0);
    con(1,1);
    con(3,2); con(3,3);
    // R7: abandoned partial load leaves example map
    load(20);
    sweep("R7 abort keeps map");
    load(50);
    sweep("R3 empty and contradiction");
    sweep("R2 complement literal");

    // R8: reset mid-operation clears map
    @(posedge clk); #1; rst_n = 1'b0;
    #1 chk(f === 4'h0, "R8 reset clears", int'(f), 0);
    and_v = '0; or_v = '0;
    @(posedge clk); #1; rst_n = 1'b1;
    sweep("R8 after reset");

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule